// File: doc/BRIEF.md
# Exclusive Access Monitor

This block keeps the reservation used by load-exclusive and store-exclusive pairs on one processor. Software builds semaphores from these pairs. A load-exclusive reserves a coarse, aligned region of memory. A later store-exclusive is allowed to write only if that reservation is still held and the store's bytes are covered by it. The block has two states: Open, with no reservation held, and Exclusive, with a reservation held. It also stores the region tag and the size of the load that set the reservation.

Each cycle the block takes at most one request. A request carries an operation code, a byte address, an access size and a fault flag raised by the translation or debug logic outside the block. For a store-exclusive the block answers in the same cycle. It gives a pass/fail status, a status-valid pulse, and a write-permit that the data path uses to decide whether the store is performed. Other processors' monitors, the cache and address translation are outside this block.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is Open with a cleared tag, so a store-exclusive issued before any load-exclusive fails.
- R2: A load-exclusive (op 2'b01) of any size (size 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 doubleword) moves the monitor to Exclusive and records the address region and the size.
- R3: The reserved region is 32 bytes aligned on a 32-byte boundary; only address bits 31..5 are stored and compared.
- R4: An ordinary store (op 2'b00) changes neither the state nor the tag, so a store-exclusive after it has the same outcome as without it.
- R5: Every store-exclusive (op 2'b10) leaves the monitor Open on the next cycle, whether it passed or failed.
- R6: A clear-exclusive (op 2'b11) leaves the monitor Open, so the next store-exclusive fails.
- R7: A store-exclusive of the same size as the recorded load passes when its start address lies in the reserved region.
- R8: A store-exclusive of a different size passes only when both its first and its last byte lie in the reserved region.
- R9: A store-exclusive with the fault flag set reports fail and keeps write-permit low, whatever the state.
- R10: A store-exclusive issued in the Open state fails with write-permit low.
- R11: For a store-exclusive, status is 0 for pass and 1 for fail. It appears in the request cycle together with a one-cycle status-valid pulse. Write-permit is high exactly on a pass. Status-valid and write-permit stay low for all other requests and idle cycles.
- R12: A load-exclusive issued while already Exclusive replaces the recorded region and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 store, 01 load-exclusive, 10 store-exclusive, 11 clear-exclusive |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 doubleword |
| req_fault | input | 1 | Fault raised for this access |
| stx_status | output | 1 | Store-exclusive result: 0 pass, 1 fail |
| stx_status_valid | output | 1 | Pulse marking a store-exclusive result |
| stx_permit | output | 1 | Store-exclusive may write memory |

## Verification
The state and tag are visible at the ports only through the answer to the next store-exclusive. A stale Exclusive bit, a lost tag or a wrong recorded size therefore shows up as a wrong pass/fail on the first store-exclusive after the error, and in the same cycle as that request. The bench uses a behavioural model of the reservation and compares against it on every cycle. It drives directed sequences aimed at region edges, mixed sizes, faults and intervening stores, and then a long random mix confined to a few neighbouring regions, so that both hits and misses occur often.

// File: rtl/excl_monitor_pkg.sv
// Shared encodings for the exclusive access monitor.
// Assumes the operation and size codes are fixed by the requesting pipeline.
package excl_monitor_pkg;
    typedef enum logic [1:0] {
        OP_STORE = 2'b00,
        OP_LDX   = 2'b01,
        OP_STX   = 2'b10,
        OP_CLR   = 2'b11
    } mon_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_DBL  = 2'b11
    } mon_size_e;

    // Number of bytes minus one for a size code.
    function automatic logic [2:0] size_last_off(input logic [1:0] sz);
        case (sz)
            2'b00:   size_last_off = 3'd0;
            2'b01:   size_last_off = 3'd1;
            2'b10:   size_last_off = 3'd3;
            default: size_last_off = 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/excl_resv_reg.sv
// Reservation register: holds the Open/Exclusive bit, the region tag and
// the size of the load that made the reservation.
// Assumes set and clear are never asserted together (the top decodes one op).
module excl_resv_reg #(
    parameter int TAG_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_resv,
    input  logic             clr_resv,
    input  logic [TAG_W-1:0] new_tag,
    input  logic [1:0]       new_size,
    output logic             excl_q,
    output logic [TAG_W-1:0] tag_q,
    output logic [1:0]       size_q
);
    // State bit: set by a load-exclusive, cleared by store-exclusive or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        excl_q <= 1'b0;
        else if (set_resv) excl_q <= 1'b1;
        else if (clr_resv) excl_q <= 1'b0;
    end

    // Tag and size: captured only by a load-exclusive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            size_q <= 2'b00;
        end else if (set_resv) begin
            tag_q  <= new_tag;
            size_q <= new_size;
        end
    end

    // R2
    ldx_sets_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_resv |=> excl_q);
    // R12
    ldx_loads_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_resv |=> (tag_q == $past(new_tag)) && (size_q == $past(new_size)));
    // R5
    clear_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_resv && !set_resv) |=> !excl_q);
endmodule

// File: rtl/excl_span_chk.sv
// Address coverage check: decides whether a store-exclusive lies in the
// reserved region. Same-size stores compare the start region only; stores
// of another size must have both first and last byte in the region.
// Assumes the region is 2**GRAN_LG2 bytes, naturally aligned.
module excl_span_chk
    import excl_monitor_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 5,
    localparam int TAG_W   = ADDR_W - GRAN_LG2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [TAG_W-1:0]  tag,
    input  logic [1:0]        tag_size,
    output logic              covered
);
    logic [ADDR_W-1:0] last_addr;
    logic              first_hit;
    logic              last_hit;
    logic              same_size;

    // Address of the final byte the store touches.
    always_comb last_addr = addr + ADDR_W'(size_last_off(size));

    // Region comparisons for both ends and the size match.
    always_comb begin
        first_hit = (addr[ADDR_W-1:GRAN_LG2] == tag);
        last_hit  = (last_addr[ADDR_W-1:GRAN_LG2] == tag);
        same_size = (size == tag_size);
    end

    // Coverage rule chosen by whether the sizes agree.
    always_comb covered = first_hit && (same_size || last_hit);
endmodule

// File: rtl/excl_monitor.sv
// Exclusive access monitor for one processor. It decodes the request,
// updates the reservation and answers store-exclusive requests in the same
// cycle with status, status-valid and write-permit.
// Assumes at most one request per cycle and that the fault flag is already
// resolved when the request is presented.
module excl_monitor
    import excl_monitor_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 5,
    localparam int TAG_W   = ADDR_W - GRAN_LG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_fault,
    output logic              stx_status,
    output logic              stx_status_valid,
    output logic              stx_permit
);
    mon_op_e          op;
    logic             is_ldx, is_stx, is_clr, is_str;
    logic             excl_q;
    logic [TAG_W-1:0] tag_q;
    logic [1:0]       size_q;
    logic             covered;
    logic             pass;

    // Decode the single request of this cycle.
    always_comb begin
        op     = mon_op_e'(req_op);
        is_ldx = req_valid && (op == OP_LDX);
        is_stx = req_valid && (op == OP_STX);
        is_clr = req_valid && (op == OP_CLR);
        is_str = req_valid && (op == OP_STORE);
    end

    excl_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_resv (is_ldx),
        .clr_resv (is_stx || is_clr),
        .new_tag  (req_addr[ADDR_W-1:GRAN_LG2]),
        .new_size (req_size),
        .excl_q   (excl_q),
        .tag_q    (tag_q),
        .size_q   (size_q)
    );

    excl_span_chk #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_span (
        .addr     (req_addr),
        .size     (req_size),
        .tag      (tag_q),
        .tag_size (size_q),
        .covered  (covered)
    );

    // Pass needs a held reservation, coverage and no fault.
    always_comb pass = is_stx && excl_q && covered && !req_fault;

    // Same-cycle response for a store-exclusive.
    always_comb begin
        stx_status_valid = is_stx;
        stx_status       = is_stx && !pass;
        stx_permit       = pass;
    end

    // R9
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stx && req_fault) |-> (stx_status && !stx_permit));
    // R10
    open_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stx && !excl_q) |-> !stx_permit);
    // R11
    permit_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stx_permit |-> (stx_status_valid && !stx_status));
    // R4
    store_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_str |=> ($stable(excl_q) && $stable(tag_q) && $stable(size_q)));
    // R6
    clear_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> !excl_q);
endmodule

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'b00;
    logic        req_fault = 1'b0;
    logic        stx_status, stx_status_valid, stx_permit;

    int n_checks = 0;
    int n_fail = 0;

    // Behavioural reference state.
    bit          m_excl = 0;
    int unsigned m_region = 0;
    int unsigned m_size = 0;

    always #5 clk = ~clk;

    excl_monitor u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .req_fault(req_fault),
        .stx_status(stx_status), .stx_status_valid(stx_status_valid),
        .stx_permit(stx_permit)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One request: drive at negedge, compare before posedge, update model after.
    task automatic step(input bit v, input int op, input int unsigned addr,
                        input int sz, input bit flt, input string tag);
        bit e_pass, is_stx;
        int unsigned nbytes, last;
        @(negedge clk);
        req_valid = v; req_op = 2'(op); req_addr = addr; req_size = 2'(sz); req_fault = flt;
        #3;
        is_stx = v && (op == 2);
        nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
        last = addr + nbytes - 1;
        e_pass = 0;
        if (is_stx && m_excl && !flt && (addr >> 5) == m_region)
            e_pass = (sz == m_size) ? 1 : ((last >> 5) == m_region);
        chk(stx_status_valid == is_stx, {tag, " R11 valid"}, stx_status_valid, is_stx);
        chk(stx_permit == e_pass, {tag, " permit"}, stx_permit, e_pass);
        if (is_stx)
            chk(stx_status == !e_pass, {tag, " R11 status"}, stx_status, !e_pass);
        @(posedge clk);
        if (v) begin
            if (op == 1) begin m_excl = 1; m_region = addr >> 5; m_size = sz; end
            else if (op == 2 || op == 3) m_excl = 0;
        end
    endtask

    initial begin
        #100000000;
        n_fail++; n_checks++;
        $display("FAIL watchdog R0 actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 idle");
        step(1, 2, 32'h0, 2, 0, "R1 stx after reset");
        step(1, 1, 32'h104, 2, 0, "R2 ldx word");
        step(1, 0, 32'h104, 2, 0, "R4 plain store");
        step(1, 2, 32'h104, 2, 0, "R7 stx pass");
        step(1, 2, 32'h104, 2, 0, "R5 R10 second stx");
        step(1, 1, 32'h100, 2, 0, "R2");
        step(1, 3, 32'h0, 0, 0, "R6 clear");
        step(1, 2, 32'h100, 2, 0, "R6 stx after clear");
        step(1, 1, 32'h11F, 0, 0, "R2 ldx byte");
        step(1, 2, 32'h118, 3, 0, "R8 dbl inside");
        step(1, 1, 32'h100, 2, 0, "R3");
        step(1, 2, 32'h11C, 3, 0, "R8 dbl crossing");
        step(1, 1, 32'h100, 3, 0, "R3");
        step(1, 2, 32'h11C, 3, 0, "R7 same size start in");
        step(1, 1, 32'h13C, 2, 0, "R3");
        step(1, 2, 32'h120, 2, 0, "R3 region base");
        step(1, 1, 32'h140, 2, 0, "R3");
        step(1, 2, 32'h13C, 2, 0, "R3 below region");
        step(1, 1, 32'h200, 2, 0, "R9");
        step(1, 2, 32'h200, 2, 1, "R9 fault");
        step(1, 2, 32'h200, 2, 0, "R9 R5 after fault");
        step(1, 2, 32'h200, 2, 1, "R9 fault open");
        step(1, 1, 32'h200, 1, 0, "R12");
        step(1, 1, 32'h300, 1, 0, "R12 reload");
        step(1, 2, 32'h200, 1, 0, "R12 old region");
        step(1, 1, 32'h200, 1, 0, "R12");
        step(1, 1, 32'h300, 1, 0, "R12 reload");
        step(1, 0, 32'h200, 1, 0, "R4 store old");
        step(1, 2, 32'h302, 1, 0, "R12 R4 new region");
        for (int i = 0; i < 4000; i++) begin
            int unsigned a;
            a = 32'h100 + ($urandom % 96);
            step($urandom % 8 != 0, $urandom % 4, a, $urandom % 4,
                 ($urandom % 10) == 0, "R7 R8 random");
        end
        @(negedge clk);
        req_valid = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule